// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address by reading page-table descriptors from memory. A request carries the virtual address and the base of the first-level table. The walker reads one first-level descriptor, which either maps a 1 MB section directly, reports a fault, or points to a second-level table. A second-level table is either coarse (1 KB, indexed by four-kilobyte steps) or fine (4 KB, indexed by one-kilobyte steps). When a second-level table is involved, the walker then reads one second-level descriptor, which maps a 64 KB, 4 KB or 1 KB page or reports a fault.

The result is a one-cycle pulse. It carries the physical address, the mapping size, the bufferable and cacheable bits, the domain, the two-bit access field that applies to the addressed quarter of the page, and a fault code. Only one walk is in flight at a time. Memory reads use a single-cycle request pulse and a response that may come back any number of cycles later. Caching of translations, permission checking and address remapping belong to the surrounding logic.

Top module: `xlat_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. A request is taken at the clock edge where `req_valid` and `req_ready` are both high. `req_valid` has no effect at any other time.
- R2: One cycle after a request is taken, `mem_req_valid` pulses for a single cycle. In that cycle `mem_req_addr` is `{base[31:14], va[31:20], 2'b00}`.
- R3: A first-level descriptor with type bits [1:0] = 00 ends the walk with fault code 1. In that case `done_dom_known`, the domain, the physical address and all attributes are 0, and no second read is made.
- R4: A first-level descriptor of type 10 (section) ends the walk with fault code 0 and size code 0. The outputs are: physical address `{d[31:20], va[19:0]}`, bufferable = d[2], cacheable = d[3], domain = d[8:5], access field = d[11:10], and `done_dom_known` = 1.
- R5: A first-level descriptor of type 01 (coarse table) causes a second read, one cycle after the first response, at `{d[31:10], va[19:12], 2'b00}`.
- R6: A first-level descriptor of type 11 (fine table) causes a second read, one cycle after the first response, at `{d[31:12], va[19:10], 2'b00}`.
- R7: A second-level descriptor with type 00 ends the walk with fault code 2. The domain is d1[8:5] of the first-level descriptor, `done_dom_known` = 1, and the physical address, size, access field and cache bits are 0.
- R8: A second-level type 01 (large page) gives physical address `{d[31:16], va[15:0]}` and size code 1. The access field is d[2k+5:2k+4], where k = va[15:14].
- R9: A second-level type 10 (small page) gives physical address `{d[31:12], va[11:0]}` and size code 2. The access field is d[2k+5:2k+4], where k = va[11:10].
- R10: A second-level type 11 (tiny page) gives physical address `{d[31:10], va[9:0]}` and size code 3. The access field is d[5:4].
- R11: `done_valid` is high for exactly the one cycle after the edge that takes the final response, and `req_ready` returns one cycle after that. A `mem_rsp_valid` that arrives outside a wait for a response has no effect.
- R12: For any page mapping, bufferable is d2[2] and cacheable is d2[3] of the second-level descriptor. The domain comes from d1[8:5] of the first-level descriptor, with `done_dom_known` = 1 and fault code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_va | input | 32 | Virtual address to translate |
| req_base | input | 32 | First-level table base (bits [31:14] used) |
| req_ready | output | 1 | Walker idle, request can be taken |
| mem_req_valid | output | 1 | One-cycle descriptor read request |
| mem_req_addr | output | 32 | Byte address of the descriptor |
| mem_rsp_valid | input | 1 | Descriptor data valid |
| mem_rsp_data | input | 32 | Descriptor word |
| done_valid | output | 1 | Result pulse |
| done_pa | output | 32 | Physical address |
| done_fault_code | output | 2 | 0 none, 1 first-level fault, 2 second-level fault |
| done_size | output | 2 | 0 section, 1 large, 2 small, 3 tiny |
| done_bufferable | output | 1 | Bufferable attribute |
| done_cacheable | output | 1 | Cacheable attribute |
| done_domain | output | 4 | Domain number |
| done_dom_known | output | 1 | Domain field is meaningful |
| done_ap | output | 2 | Access field for the addressed subpage |

## Verification
Take acceptance as cycle 0 and let L be the memory latency. The first read is due in cycle 1. A section or first-level fault result is due in cycle L+2. The second read is due in cycle L+2, and a two-level result is due in cycle 2L+3. The bench replays each walk against a behavioural reference that works out these cycle numbers from L. Every clock it compares the read strobe, the result pulse and the ready flag against that reference, and it compares the read address and all result fields exactly in the cycles where they are due. While the walk is in progress, the bench holds a junk request and injects stray responses, so that any wrongly accepted input would show up as an early or misplaced strobe.

// File: rtl/xw_pkg.sv
// Package: shared widths, shift positions, encodings and the result record
// used by the translation table walker. Assumes 32-bit addresses and
// descriptors.
package xw_pkg;
    parameter int unsigned ADDR_W     = 32;
    parameter int unsigned DESC_W     = 32;
    parameter int unsigned DOM_W      = 4;
    parameter int unsigned AP_W       = 2;
    parameter int unsigned SUBPAGES   = 4;

    // Address-split positions
    localparam int unsigned L1_TBL_SH   = 14;  // 16 KB first-level table
    localparam int unsigned SECTION_SH  = 20;  // 1 MB
    localparam int unsigned LARGE_SH    = 16;  // 64 KB
    localparam int unsigned SMALL_SH    = 12;  // 4 KB
    localparam int unsigned TINY_SH     = 10;  // 1 KB
    localparam int unsigned COARSE_SH   = 10;  // coarse table alignment
    localparam int unsigned FINE_SH     = 12;  // fine table alignment
    localparam int unsigned WORD_SH     = 2;   // descriptor byte offset
    localparam int unsigned DOM_LSB     = 5;
    localparam int unsigned SEC_AP_LSB  = 10;
    localparam int unsigned PG_AP_LSB   = 4;
    localparam int unsigned BUF_BIT     = 2;
    localparam int unsigned CACHE_BIT   = 3;
    localparam int unsigned SEL_W       = $clog2(SUBPAGES);

    typedef enum logic [1:0] {
        L1_FAULT = 2'd0, L1_COARSE = 2'd1, L1_SECTION = 2'd2, L1_FINE = 2'd3
    } l1_kind_e;

    typedef enum logic [1:0] {
        L2_FAULT = 2'd0, L2_LARGE = 2'd1, L2_SMALL = 2'd2, L2_TINY = 2'd3
    } l2_kind_e;

    typedef enum logic [1:0] {
        SZ_SECTION = 2'd0, SZ_LARGE = 2'd1, SZ_SMALL = 2'd2, SZ_TINY = 2'd3
    } map_size_e;

    typedef enum logic [1:0] {
        FC_NONE = 2'd0, FC_LEVEL1 = 2'd1, FC_LEVEL2 = 2'd2
    } fault_code_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_L1_RD, ST_L1_WAIT, ST_L2_RD, ST_L2_WAIT, ST_DONE
    } walk_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] pa;
        fault_code_e       fcode;
        map_size_e         size;
        logic              bufferable;
        logic              cacheable;
        logic [DOM_W-1:0]  domain;
        logic              dom_known;
        logic [AP_W-1:0]   ap;
    } walk_result_t;

    // Keep descriptor bits above the page boundary, address bits below it.
    function automatic logic [ADDR_W-1:0] splice_pa(
        input logic [DESC_W-1:0] d,
        input logic [ADDR_W-1:0] va,
        input int unsigned       sh
    );
        logic [ADDR_W-1:0] frame_mask;
        frame_mask = {ADDR_W{1'b1}} << sh;
        return (ADDR_W'(d) & frame_mask) | (va & ~frame_mask);
    endfunction
endpackage

// File: rtl/xw_l1_decode.sv
// First-level descriptor decoder (combinational).
// Splits a first-level word into its kind, a finished result (for a section
// or a fault) and the second-level descriptor address (for a table pointer).
// Assumes desc is the word fetched for virtual address va.
module xw_l1_decode
    import xw_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    input  logic [ADDR_W-1:0] va,
    output l1_kind_e          kind,
    output logic [DOM_W-1:0]  domain,
    output logic [ADDR_W-1:0] l2_addr,
    output walk_result_t      res
);
    logic unused_bits;
    assign unused_bits = ^{desc[9], desc[4]};

    // Type and domain are at fixed positions for every kind.
    always_comb begin
        kind   = l1_kind_e'(desc[1:0]);
        domain = desc[DOM_LSB +: DOM_W];
    end

    // Second-level pointer: alignment depends on table kind.
    always_comb begin
        if (kind == L1_FINE)
            l2_addr = {desc[DESC_W-1:FINE_SH], va[SECTION_SH-1:TINY_SH],
                       {WORD_SH{1'b0}}};
        else
            l2_addr = {desc[DESC_W-1:COARSE_SH], va[SECTION_SH-1:SMALL_SH],
                       {WORD_SH{1'b0}}};
    end

    // Result record for the walks that finish at the first level.
    always_comb begin
        res = '0;
        if (kind == L1_FAULT) begin
            res.fcode = FC_LEVEL1;
        end else if (kind == L1_SECTION) begin
            res.fcode      = FC_NONE;
            res.size       = SZ_SECTION;
            res.pa         = splice_pa(desc, va, SECTION_SH);
            res.bufferable = desc[BUF_BIT];
            res.cacheable  = desc[CACHE_BIT];
            res.domain     = desc[DOM_LSB +: DOM_W];
            res.dom_known  = 1'b1;
            res.ap         = desc[SEC_AP_LSB +: AP_W];
        end
    end
endmodule

// File: rtl/xw_l2_decode.sv
// Second-level descriptor decoder (combinational).
// Builds the final result from a second-level word, the virtual address and
// the domain carried over from the first-level pointer. Assumes desc was
// fetched from the table that va indexes.
module xw_l2_decode
    import xw_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    input  logic [ADDR_W-1:0] va,
    input  logic [DOM_W-1:0]  domain,
    output walk_result_t      res
);
    l2_kind_e          kind;
    logic [AP_W-1:0]   ap_field [SUBPAGES];
    logic [SEL_W-1:0]  sub_sel;

    // One access field per quarter subpage.
    for (genvar g = 0; g < SUBPAGES; g++) begin : g_ap
        assign ap_field[g] = desc[PG_AP_LSB + AP_W*g +: AP_W];
    end

    // Pick the subpage from the address bits just below the page boundary.
    always_comb begin
        kind = l2_kind_e'(desc[1:0]);
        unique case (kind)
            L2_LARGE: sub_sel = va[LARGE_SH-1 -: SEL_W];
            L2_SMALL: sub_sel = va[SMALL_SH-1 -: SEL_W];
            default:  sub_sel = '0;
        endcase
    end

    // Assemble the result for the page size given by the type bits.
    always_comb begin
        res = '0;
        res.domain    = domain;
        res.dom_known = 1'b1;
        if (kind == L2_FAULT) begin
            res.fcode = FC_LEVEL2;
        end else begin
            res.fcode      = FC_NONE;
            res.bufferable = desc[BUF_BIT];
            res.cacheable  = desc[CACHE_BIT];
            res.ap         = ap_field[sub_sel];
            unique case (kind)
                L2_LARGE: begin
                    res.size = SZ_LARGE;
                    res.pa   = splice_pa(desc, va, LARGE_SH);
                end
                L2_SMALL: begin
                    res.size = SZ_SMALL;
                    res.pa   = splice_pa(desc, va, SMALL_SH);
                end
                default: begin
                    res.size = SZ_TINY;
                    res.pa   = splice_pa(desc, va, TINY_SH);
                end
            endcase
        end
    end
endmodule

// File: rtl/xw_seq.sv
// Walk sequencer.
// Steps through idle, first read, first wait, optional second read and wait,
// and a one-cycle done state. Assumes the memory answers every read exactly
// once, and ignores any response outside the two wait states.
module xw_seq
    import xw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        rsp_valid,
    input  l1_kind_e    l1_kind,
    output walk_state_e state,
    output logic        accept,
    output logic        l1_take,
    output logic        l2_take
);
    walk_state_e state_nx;

    // Handshake qualifiers for the datapath.
    always_comb begin
        accept  = (state == ST_IDLE) && req_valid;
        l1_take = (state == ST_L1_WAIT) && rsp_valid;
        l2_take = (state == ST_L2_WAIT) && rsp_valid;
    end

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (accept) state_nx = ST_L1_RD;
            ST_L1_RD:   state_nx = ST_L1_WAIT;
            ST_L1_WAIT: if (l1_take)
                            state_nx = (l1_kind == L1_COARSE || l1_kind == L1_FINE)
                                       ? ST_L2_RD : ST_DONE;
            ST_L2_RD:   state_nx = ST_L2_WAIT;
            ST_L2_WAIT: if (l2_take) state_nx = ST_DONE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_L1_WAIT && !rsp_valid) |=> (state == ST_L1_WAIT)); // R11
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !req_valid) |=> (state == ST_IDLE)); // R1
endmodule

// File: rtl/xlat_walker.sv
// Two-level translation table walker, top level.
// Registers the request, drives descriptor reads, routes responses into the
// two decoders and holds the result for the one-cycle done pulse. Assumes
// one outstanding memory read and one walk at a time.
module xlat_walker
    import xw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_va,
    input  logic [ADDR_W-1:0] req_base,
    output logic              req_ready,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DESC_W-1:0] mem_rsp_data,
    output logic              done_valid,
    output logic [ADDR_W-1:0] done_pa,
    output logic [1:0]        done_fault_code,
    output logic [1:0]        done_size,
    output logic              done_bufferable,
    output logic              done_cacheable,
    output logic [DOM_W-1:0]  done_domain,
    output logic              done_dom_known,
    output logic [AP_W-1:0]   done_ap
);
    walk_state_e                   state;
    logic                          accept, l1_take, l2_take;
    l1_kind_e                      l1_kind;
    logic [DOM_W-1:0]              l1_domain;
    logic [ADDR_W-1:0]             l1_next_addr;
    walk_result_t                  l1_res, l2_res, res_q;
    logic [ADDR_W-1:0]             va_q;
    logic [ADDR_W-1:L1_TBL_SH]     base_hi_q;
    logic [DOM_W-1:0]              dom_q;
    logic [ADDR_W-1:0]             l2_addr_q;
    logic [ADDR_W-1:0]             l1_addr;
    logic unused_base;
    assign unused_base = ^req_base[L1_TBL_SH-1:0];

    xw_seq i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .rsp_valid (mem_rsp_valid),
        .l1_kind   (l1_kind),
        .state     (state),
        .accept    (accept),
        .l1_take   (l1_take),
        .l2_take   (l2_take)
    );

    xw_l1_decode i_l1 (
        .desc    (mem_rsp_data),
        .va      (va_q),
        .kind    (l1_kind),
        .domain  (l1_domain),
        .l2_addr (l1_next_addr),
        .res     (l1_res)
    );

    xw_l2_decode i_l2 (
        .desc   (mem_rsp_data),
        .va     (va_q),
        .domain (dom_q),
        .res    (l2_res)
    );

    // First-level descriptor address: table base plus section index.
    always_comb begin
        l1_addr = {base_hi_q, va_q[ADDR_W-1:SECTION_SH], {WORD_SH{1'b0}}};
    end

    // Request capture and walk bookkeeping registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q      <= '0;
            base_hi_q <= '0;
            dom_q     <= '0;
            l2_addr_q <= '0;
            res_q     <= '0;
        end else begin
            if (accept) begin
                va_q      <= req_va;
                base_hi_q <= req_base[ADDR_W-1:L1_TBL_SH];
            end
            if (l1_take) begin
                if (l1_kind == L1_COARSE || l1_kind == L1_FINE) begin
                    l2_addr_q <= l1_next_addr;
                    dom_q     <= l1_domain;
                end else begin
                    res_q <= l1_res;
                end
            end
            if (l2_take) res_q <= l2_res;
        end
    end

    // Port drive from state and held registers.
    always_comb begin
        req_ready       = (state == ST_IDLE);
        mem_req_valid   = (state == ST_L1_RD) || (state == ST_L2_RD);
        mem_req_addr    = (state == ST_L2_RD) ? l2_addr_q : l1_addr;
        done_valid      = (state == ST_DONE);
        done_pa         = res_q.pa;
        done_fault_code = res_q.fcode;
        done_size       = res_q.size;
        done_bufferable = res_q.bufferable;
        done_cacheable  = res_q.cacheable;
        done_domain     = res_q.domain;
        done_dom_known  = res_q.dom_known;
        done_ap         = res_q.ap;
    end

    AST_READ_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> mem_req_valid); // R2
    AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid); // R2
    AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready); // R1
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> (!done_valid && req_ready)); // R11
    AST_L1_FAULT_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_fault_code == FC_LEVEL1)
        |-> (!done_dom_known && done_pa == '0)); // R3
    AST_L2_FAULT_DOM: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_fault_code == FC_LEVEL2) |-> done_dom_known); // R7
    AST_SMALL_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_fault_code == FC_NONE && done_size == SZ_SMALL)
        |-> (done_pa[SMALL_SH-1:0] == va_q[SMALL_SH-1:0])); // R9
endmodule

// File: tb/test_xlat_walker.sv
module test_xlat_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic [31:0] req_base = '0;
    logic        req_ready;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done_valid;
    logic [31:0] done_pa;
    logic [1:0]  done_fault_code;
    logic [1:0]  done_size;
    logic        done_bufferable;
    logic        done_cacheable;
    logic [3:0]  done_domain;
    logic        done_dom_known;
    logic [1:0]  done_ap;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    xlat_walker i_xlat_walker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_va(req_va), .req_base(req_base),
        .req_ready(req_ready),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done_valid(done_valid), .done_pa(done_pa),
        .done_fault_code(done_fault_code), .done_size(done_size),
        .done_bufferable(done_bufferable), .done_cacheable(done_cacheable),
        .done_domain(done_domain), .done_dom_known(done_dom_known),
        .done_ap(done_ap)
    );

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural model of one walk: expected addresses and result fields.
    task automatic ref_walk(
        input  logic [31:0] va, base, d1, d2,
        output bit          two, output logic [31:0] a1, a2, pa,
        output int fc, sz, b, c, dom, dk, ap
    );
        int sel;
        two = 0; a2 = 0; pa = 0; fc = 0; sz = 0; b = 0; c = 0;
        dom = 0; dk = 0; ap = 0;
        a1 = (base & 32'hFFFF_C000) | ((va >> 20) << 2);
        case (d1[1:0])
            2'b00: fc = 1;
            2'b10: begin
                pa = (d1 & 32'hFFF0_0000) | (va & 32'h000F_FFFF);
                b = d1[2]; c = d1[3]; dom = int'(d1[8:5]); dk = 1;
                ap = int'(d1[11:10]);
            end
            default: begin
                two = 1; dom = int'(d1[8:5]); dk = 1;
                if (d1[1:0] == 2'b01)
                    a2 = (d1 & 32'hFFFF_FC00) | (((va >> 12) & 32'hFF) << 2);
                else
                    a2 = (d1 & 32'hFFFF_F000) | (((va >> 10) & 32'h3FF) << 2);
                case (d2[1:0])
                    2'b00: fc = 2;
                    2'b01: begin
                        sz = 1; pa = (d2 & 32'hFFFF_0000) | (va & 32'hFFFF);
                        sel = int'(va[15:14]);
                    end
                    2'b10: begin
                        sz = 2; pa = (d2 & 32'hFFFF_F000) | (va & 32'hFFF);
                        sel = int'(va[11:10]);
                    end
                    default: begin
                        sz = 3; pa = (d2 & 32'hFFFF_FC00) | (va & 32'h3FF);
                        sel = 0;
                    end
                endcase
                if (d2[1:0] != 2'b00) begin
                    b = d2[2]; c = d2[3];
                    ap = int'((d2 >> (4 + 2*sel)) & 32'h3);
                end
            end
        endcase
    endtask

    // Run one walk; called at a negedge while idle, returns at a negedge.
    task automatic walk(input int lat, input logic [31:0] va, base, d1, d2,
                        input string tag);
        bit two; logic [31:0] a1, a2, pa;
        int fc, sz, b, c, dom, dk, ap, done_c;
        ref_walk(va, base, d1, d2, two, a1, a2, pa, fc, sz, b, c, dom, dk, ap);
        done_c = two ? 3 + 2*lat : 2 + lat;
        req_valid = 1'b1; req_va = va; req_base = base;
        mem_rsp_valid = 1'b1; mem_rsp_data = 32'hFFFF_FFFE; // stray while idle
        for (int cyc = 1; cyc <= done_c + 1; cyc++) begin
            @(negedge clk);
            // junk request held while busy (R1), stray responses (R11)
            req_valid = (cyc < done_c);
            req_va = ~va; req_base = ~base;
            mem_rsp_valid = (cyc == 1) || (cyc == 1 + lat) ||
                            (two && cyc == 2 + 2*lat) || (cyc == done_c);
            if (cyc == 1 + lat)                 mem_rsp_data = d1;
            else if (two && cyc == 2 + 2*lat)   mem_rsp_data = d2;
            else                                mem_rsp_data = 32'h5A5A_5A5A;
            check({tag, " R2 read strobe"}, 32'(mem_req_valid),
                  32'(cyc == 1 || (two && cyc == 2 + lat)));
            if (cyc == 1) check({tag, " R2 first address"}, mem_req_addr, a1);
            if (two && cyc == 2 + lat)
                check({tag, " second address"}, mem_req_addr, a2);
            check({tag, " R11 done pulse"}, 32'(done_valid), 32'(cyc == done_c));
            check({tag, " R1 ready"}, 32'(req_ready), 32'(cyc == done_c + 1));
            if (cyc == done_c) begin
                check({tag, " pa"}, done_pa, pa);
                check({tag, " fault code"}, 32'(done_fault_code), 32'(fc));
                check({tag, " size"}, 32'(done_size), 32'(sz));
                check({tag, " bufferable"}, 32'(done_bufferable), 32'(b));
                check({tag, " cacheable"}, 32'(done_cacheable), 32'(c));
                check({tag, " domain"}, 32'(done_domain), 32'(dom));
                check({tag, " dom known"}, 32'(done_dom_known), 32'(dk));
                check({tag, " ap"}, 32'(done_ap), 32'(ap));
            end
        end
        req_valid = 1'b0; mem_rsp_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset ready", 32'(req_ready), 32'd1);
        check("R2 reset strobe", 32'(mem_req_valid), 32'd0);
        check("R11 reset done", 32'(done_valid), 32'd0);

        walk(1, 32'h1234_5678, 32'h8000_4000, 32'hABCD_E000, 0, "R3 l1 fault");
        walk(3, 32'h89AB_CDEF, 32'h0003_FFFF, 32'h0000_0DDC, 0, "R3 l1 fault slow");
        walk(2, 32'h0ABC_DEF1, 32'h0001_C000, 32'h9F30_094A, 0, "R4 section");
        walk(1, 32'hFFFF_FFFF, 32'hFFFF_C000, 32'hFFF0_0DE6, 0, "R4 section b");
        for (int k = 0; k < 4; k++)
            walk(1 + k % 2, 32'h3456_0123 | (32'(k) << 14), 32'h0020_8000,
                 32'h1234_5561, 32'hCAFE_0E4D, "R5 R8 R12 coarse large");
        for (int k = 0; k < 4; k++)
            walk(2, 32'h7FFF_F0AB | (32'(k) << 10), 32'h0000_0000,
                 32'h2468_ACE1, 32'h7654_3E4A, "R5 R9 R12 coarse small");
        walk(1, 32'h4321_8765, 32'h1000_0000, 32'hFEDC_B821, 32'h89AB_CDB7,
             "R5 R10 R12 coarse tiny");
        walk(2, 32'hC0DE_BEEF, 32'h5555_4000, 32'h4567_8FF3, 32'h0000_0433,
             "R6 R10 R12 fine tiny");
        walk(1, 32'h0123_4C56, 32'h0000_C000, 32'h1357_9A53, 32'hB00F_1E86,
             "R6 R9 R12 fine small");
        walk(3, 32'h00F0_8000, 32'h7777_0000, 32'h0000_1FBF, 32'h5000_0A95,
             "R6 R8 R12 fine large");
        walk(1, 32'hDEAD_BEEF, 32'h0004_0000, 32'h0BAD_F0A1, 32'hFFFF_FFFC,
             "R5 R7 coarse l2 fault");
        walk(2, 32'h1111_2222, 32'h2222_8000, 32'h3333_40FF, 32'h0000_0000,
             "R6 R7 fine l2 fault");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule